// File: doc/BRIEF.md
# Prioritised Multi-Message Byte Streamer

This block holds three fixed ASCII messages and streams the characters of one of them, a byte per accepted transfer, towards a byte consumer such as a serial transmitter's input queue. Requests arrive as a set of flags, one per message. The block's output side is a plain valid/ready byte stream. A byte moves only in a cycle where both `out_valid` and `out_ready` are high. The consumer is free to hold `out_ready` low for as long as it needs, for example while its queue is full.

While the streamer is idle it picks the lowest-numbered raised flag and starts that message at character zero. Each message has its own character counter, sized to the message. The counter sits beside the character lookup and moves only on an accepted transfer, so no character can be skipped or repeated. When the last character is accepted, `out_valid` falls. In the next cycle the message's `done` bit pulses for one cycle, and new requests can be taken again.

The texts are fixed:
- message 0 is `LINK UP` followed by carriage return and line feed (9 bytes);
- message 1 is `TEMP=42` followed by line feed (8 bytes);
- message 2 is `BYE` followed by carriage return and line feed (5 bytes).

Top module: `msg_stream`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0 and `done` is 0.
- R2: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` keeps its value in the next cycle.
- R3: In an idle cycle with any `req` bit set, the message picked is the lowest-numbered set bit (bit 0 wins over bit 1, and bit 1 over bit 2). `out_valid` rises in the next cycle.
- R4: After a start, the first byte presented is character zero of the message. Each accepted transfer then presents the next character in text order.
- R5: The character position advances only on an accepted transfer. Once the last character is accepted, `out_valid` is 0 in the next cycle. After any other accepted transfer, `out_valid` stays 1.
- R6: In the cycle after the last character of message k is accepted, `done` equals a one-hot word with bit k set, for exactly one cycle. At every other time `done` is 0.
- R7: `req` is ignored while a message is being sent. The message in progress completes unchanged, and a pending request starts only once the block is idle again.
- R8: The accepted byte stream of each message equals its text exactly: message 0 "LINK UP\r\n", message 1 "TEMP=42\n", message 2 "BYE\r\n". A message requested again restarts from character zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 3 | Message request flags; bit k requests message k |
| out_ready | input | 1 | Consumer can accept a byte this cycle |
| out_data | output | 8 | Current character |
| out_valid | output | 1 | `out_data` holds a character to transfer |
| done | output | 3 | One-cycle pulse; bit k marks the end of message k |

## Verification
The hardest case to reach from the ports is a higher-priority request that rises partway through a lower-priority message. In that case the message in progress must finish untouched, and the pending message must then begin cleanly at character zero. The stimulus starts message 2, raises flag 0 two cycles later and holds it high under random backpressure. The bench compares the full received text of message 2 and then that of message 0. A forced stall of several cycles is added mid-message, and messages are requested again back to back, to cover the hold rule and the restart from character zero.

// File: rtl/msg_stream_pkg.sv
package msg_stream_pkg;
  localparam int NUM_MSG = 3;
  localparam int BYTE_W  = 8;

  localparam int LEN0 = 9;
  localparam int LEN1 = 8;
  localparam int LEN2 = 5;
  localparam int MAX_LEN = (LEN0 > LEN1) ? ((LEN0 > LEN2) ? LEN0 : LEN2)
                                         : ((LEN1 > LEN2) ? LEN1 : LEN2);

  localparam logic [8*LEN0-1:0] TXT0 = "LINK UP\015\012";
  localparam logic [8*LEN1-1:0] TXT1 = "TEMP=42\012";
  localparam logic [8*LEN2-1:0] TXT2 = "BYE\015\012";

  // Minimum counter width that addresses positions 0 .. len-1.
  function automatic int idx_width(int len);
    return (len > 1) ? $clog2(len) : 1;
  endfunction

  localparam int IDX_W = idx_width(MAX_LEN);

  function automatic int msg_len(int m);
    case (m)
      0:       return LEN0;
      1:       return LEN1;
      default: return LEN2;
    endcase
  endfunction

  // Character i (0 = first) of message m; zero when i is out of range.
  function automatic logic [BYTE_W-1:0] msg_char(int m, int i);
    if (i < 0 || i >= msg_len(m)) return '0;
    case (m)
      0:       return TXT0[8*(LEN0-1-i) +: 8];
      1:       return TXT1[8*(LEN1-1-i) +: 8];
      default: return TXT2[8*(LEN2-1-i) +: 8];
    endcase
  endfunction
endpackage

// File: rtl/msg_pick.sv
module msg_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  // Lowest-numbered raised flag wins.
  for (genvar k = 0; k < N; k++) begin : g_pick
    if (k == 0) begin : g_first
      assign grant[k] = req[k];
    end else begin : g_rest
      assign grant[k] = req[k] & ~(|req[k-1:0]);
    end
  end
endmodule

// File: rtl/msg_index.sv
module msg_index #(
  parameter int LEN = 8,
  localparam int W = msg_stream_pkg::idx_width(LEN)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] idx,
  output logic         at_last
);
  assign at_last = (idx == W'(LEN - 1));

  always_ff @(posedge clk) begin
    if (rst || clear)          idx <= '0;
    else if (step && !at_last) idx <= idx + W'(1);
  end
endmodule

// File: rtl/msg_rom.sv
module msg_rom
  import msg_stream_pkg::*;
(
  input  logic [NUM_MSG-1:0]            sel,
  input  logic [NUM_MSG-1:0][IDX_W-1:0] idx_arr,
  output logic [BYTE_W-1:0]             data
);
  logic [NUM_MSG-1:0][BYTE_W-1:0] part;

  // AND-OR selection: each message gates its own character.
  for (genvar g = 0; g < NUM_MSG; g++) begin : g_part
    assign part[g] = {BYTE_W{sel[g]}} & msg_char(g, int'(idx_arr[g]));
  end

  always_comb begin
    data = '0;
    for (int g = 0; g < NUM_MSG; g++) data = data | part[g];
  end
endmodule

// File: rtl/msg_stream.sv
module msg_stream
  import msg_stream_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_MSG-1:0] req,
  input  logic               out_ready,
  output logic [BYTE_W-1:0]  out_data,
  output logic               out_valid,
  output logic [NUM_MSG-1:0] done
);
  logic                            busy_q;
  logic [NUM_MSG-1:0]              sel_q;
  logic [NUM_MSG-1:0]              done_q;
  logic [NUM_MSG-1:0]              grant_w;
  logic [NUM_MSG-1:0]              at_last_vec;
  logic [NUM_MSG-1:0][IDX_W-1:0]   idx_arr;

  // Named events, also used by the checker.
  logic start_w, fire_w, last_w;

  assign start_w = !busy_q && (|req);
  assign fire_w  = busy_q && out_ready;
  assign last_w  = |(sel_q & at_last_vec);

  msg_pick #(.N(NUM_MSG)) u_pick (.req(req), .grant(grant_w));

  for (genvar g = 0; g < NUM_MSG; g++) begin : g_msg
    localparam int L = msg_len(g);
    localparam int W = idx_width(L);
    logic [W-1:0] idx_g;

    msg_index #(.LEN(L)) u_idx (
      .clk     (clk),
      .rst     (rst),
      .clear   (start_w & grant_w[g]),
      .step    (fire_w & sel_q[g]),
      .idx     (idx_g),
      .at_last (at_last_vec[g])
    );
    assign idx_arr[g] = IDX_W'(idx_g);
  end

  msg_rom u_rom (.sel(sel_q), .idx_arr(idx_arr), .data(out_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sel_q  <= '0;
      done_q <= '0;
    end else begin
      done_q <= '0;
      if (start_w) begin
        busy_q <= 1'b1;
        sel_q  <= grant_w;
      end else if (fire_w && last_w) begin
        busy_q <= 1'b0;
        sel_q  <= '0;
        done_q <= sel_q;
      end
    end
  end

  assign out_valid = busy_q;
  assign done      = done_q;
endmodule

// File: rtl/msg_stream_chk.sv
module msg_stream_chk
  import msg_stream_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               out_valid,
  input logic               out_ready,
  input logic [BYTE_W-1:0]  out_data,
  input logic [NUM_MSG-1:0] done,
  input logic [NUM_MSG-1:0] grant_w,
  input logic               start_w,
  input logic               fire_w,
  input logic               last_w
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!out_valid && done == '0));

  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r3_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_w));

  a_r3_valid_after_start: assert property (@(posedge clk) disable iff (rst)
    start_w |=> out_valid);

  a_r5_drop_after_last: assert property (@(posedge clk) disable iff (rst)
    (fire_w && last_w) |=> !out_valid);

  a_r5_keep_mid_message: assert property (@(posedge clk) disable iff (rst)
    (fire_w && !last_w) |=> out_valid);

  a_r6_done_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done));

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (rst)
    (fire_w && last_w) |=> (done != '0));

  a_r7_start_only_idle: assert property (@(posedge clk) disable iff (rst)
    start_w |-> !out_valid);
endmodule

bind msg_stream msg_stream_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .done      (done),
  .grant_w   (grant_w),
  .start_w   (start_w),
  .fire_w    (fire_w),
  .last_w    (last_w)
);

// File: tb/msg_stream_test.sv
`timescale 1ns/100ps
module msg_stream_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] req = '0;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_valid;
  logic [2:0] done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  string txt [3] = '{"LINK UP\015\012", "TEMP=42\012", "BYE\015\012"};

  // Behavioural reference state.
  bit m_busy = 0;
  int m_sel  = 0;
  int m_idx  = 0;
  bit [2:0] m_done = '0;
  string rx = "";

  always #2.5 clk = ~clk;

  msg_stream uut (
    .clk(clk), .rst(rst), .req(req), .out_ready(out_ready),
    .out_data(out_data), .out_valid(out_valid), .done(done)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Reference model update at each rising edge.
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_sel = 0; m_idx = 0; m_done = '0;
    end else begin
      m_done = '0;
      if (!m_busy) begin
        if (req != 0) begin
          m_sel  = req[0] ? 0 : (req[1] ? 1 : 2);
          m_busy = 1;
          m_idx  = 0;
        end
      end else if (out_ready) begin
        if (m_idx == txt[m_sel].len() - 1) begin
          m_busy = 0;
          m_done[m_sel] = 1'b1;
        end else begin
          m_idx++;
        end
      end
    end
  end

  // Cycle-by-cycle comparison on the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      check(out_valid == m_busy, "R5 valid", out_valid, m_busy);
      check(done == m_done, "R6 done", done, m_done);
      if (m_busy)
        check(out_data == txt[m_sel][m_idx], "R4 data", out_data, txt[m_sel][m_idx]);
      for (int k = 0; k < 3; k++) begin
        if (done[k]) begin
          check(rx == txt[k], (k == 2) ? "R7 msg2 completed" : "R8 text",
                rx.len(), txt[k].len());
          rx = "";
        end
      end
      if (out_valid && out_ready) rx = {rx, string'(out_data)};
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic step(int pct);
    out_ready = ($urandom % 100) < pct;
    @(posedge clk); #1;
  endtask

  task automatic pulse_and_drain(logic [2:0] r, int pct);
    req = r;
    step(pct);
    req = '0;
    for (int i = 0; i < 2000 && m_busy; i++) step(pct);
    step(pct);
  endtask

  initial begin
    repeat (3) begin
      @(posedge clk); #1;
      check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
      check(done == 3'b000, "R1 done in reset", done, 0);
    end
    rst = 1'b0;
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);

    // First message, first character must be present.
    pulse_and_drain(3'b001, 60);

    // Priority: flags 1 and 2 together pick message 1.
    out_ready = 1'b0;
    req = 3'b110;
    @(posedge clk); #1;
    req = '0;
    check(out_valid == 1'b1, "R3 valid after start", out_valid, 1);
    check(out_data == "T", "R3 message 1 chosen", out_data, "T");
    // Stall: data and valid held.
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      check(out_valid && out_data == "T", "R2 hold while stalled", out_data, "T");
    end
    for (int i = 0; i < 2000 && m_busy; i++) step(70);
    step(70);

    // All flags: message 0 wins.
    pulse_and_drain(3'b111, 100);

    // Request during a message: message 2 completes, then message 0.
    req = 3'b100;
    step(50);
    req = '0;
    step(50);
    req = 3'b001;
    for (int i = 0; i < 2000 && !(m_busy && m_sel == 0); i++) step(50);
    req = '0;
    check(m_sel == 0, "R7 pending request served", m_sel, 0);
    for (int i = 0; i < 2000 && m_busy; i++) step(50);
    step(50);

    // Restart the same message back to back.
    pulse_and_drain(3'b010, 80);
    pulse_and_drain(3'b010, 30);

    // Random traffic.
    for (int i = 0; i < 400; i++) begin
      req = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      step(55);
    end
    req = '0;
    for (int i = 0; i < 2000 && m_busy; i++) step(55);
    step(55);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule